// File: doc/BRIEF.md
# Saturation-Driven Auto-Range Controller

This controller sets the range of a capacitive measurement front end. The front end compares a sensor against a programmable bank of reference capacitors, and the capacitors are binary weighted. An external peak comparator raises an asynchronous saturation flag whenever the sensor exceeds the bank by 100 pF or more. On every step tick the controller samples that flag. If the flag is high, it raises the bank code by one and pulses a clear to the peak-hold stage, so that the old peak does not trigger the next step. When the flag stays low, the code holds. That held code is the coarse reading. The step tick is a single-cycle clock enable from a divider elsewhere on the chip, nominally 700 Hz.

Once the loop has settled, a signed fine difference from the ADC arrives on a valid/ready stream. The controller clamps it to the span of one bank step and adds it to the coarse value. It then offers the absolute capacitance in femtofarads on a second valid/ready stream.

Back-pressure rules:
- The fine input is accepted only while the loop is settled and the single output slot is free or being drained in the same cycle.
- A result stays valid, with its data unchanged, until the consumer takes it.
- A start strobe drops any pending result.

Top module: `autorange_ctrl`

## Requirements
- R1: The saturation flag is sampled through a two-flop synchronizer. The bank code rises by exactly one only on a clock where `step_tick` is high and the synchronized flag is high. On every other clock the code holds, whatever the flag does.
- R2: `pdet_clr` is high for exactly one cycle, the cycle after each tick that finds the flag high, and is low otherwise.
- R3: A tick with the flag high at code 127 leaves the code at 127 and sets `over_range`. `over_range` stays set until a start strobe, even after the flag falls.
- R4: `settled` rises on the second consecutive tick that finds the flag low since the last advance or start. It drops on any tick that finds the flag high.
- R5: A start strobe clears the code, `settled`, `over_range` and `meas_valid` on the next edge. Start wins over a tick in the same cycle.
- R6: Bit i of `bank_code` selects a capacitor of 100 pF × 2^i. For a sensor of C femtofarads below 12 800 000, the loop settles at code floor(C / 100 000). For example, a 5 nF sensor settles at code 50 (binary 0110010).
- R7: The fine input is signed two's complement in femtofarads. It is clamped to the range 0..100 000 before use.
- R8: `meas_data` equals `bank_code` × 100 000 plus the clamped fine value, as a 24-bit unsigned number. It becomes valid on the clock after the fine handshake.
- R9: `fine_ready` is high only while `settled` is high and the output slot is empty or being taken. While `meas_valid` is high and `meas_ready` is low, `meas_valid` and `meas_data` stay unchanged.
- R10: After reset, the code is 0 and `pdet_clr`, `settled`, `over_range`, `fine_ready` and `meas_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart strobe, one cycle |
| step_tick | input | 1 | Range-step clock enable, one cycle |
| sat_async | input | 1 | Asynchronous saturation flag from the peak comparator |
| pdet_clr | output | 1 | Peak-hold discharge pulse |
| bank_code | output | 7 | Reference bank switch code, bit i for capacitor 100 pF × 2^i |
| settled | output | 1 | Loop holds its code |
| over_range | output | 1 | Sensor beyond the bank span |
| fine_valid | input | 1 | Fine difference word offered |
| fine_ready | output | 1 | Fine difference word accepted this cycle |
| fine_data | input | 20 | Signed fine difference in fF |
| meas_valid | output | 1 | Absolute result offered |
| meas_ready | input | 1 | Consumer takes result |
| meas_data | output | 24 | Absolute capacitance in fF |

## Verification
The synchronizer adds two clocks of latency. The bank code and `pdet_clr` change on the edge that samples a tick, and `settled` follows from the tick pattern. The result appears on the clock after the fine handshake. The bench therefore spaces ticks eight clocks apart, so the sensor model's response to a new code has passed through the synchronizer before the next tick. It drives and samples only on falling edges, reading the code and pulse on the falling edge just after each tick, and the result on the falling edge after the accepting edge. Settling time is checked tick by tick on a short run, and the held result is read across several stalled cycles.

// File: rtl/arc_pkg.sv
package arc_pkg;
  localparam int ARC_CODE_W = 7;
  localparam int ARC_LSB_FF = 100000;
  localparam int ARC_FINE_W = 20;
  localparam int ARC_OUT_W  = 24;
  localparam int ARC_SETTLE = 2;
endpackage

// File: rtl/arc_sync.sv
module arc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/arc_stepper.sv
module arc_stepper #(
  parameter int CODE_W = 7,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step_tick,
  input  logic              sat_q,
  output logic [CODE_W-1:0] code,
  output logic              pdet_clr,
  output logic              settled,
  output logic              over_range
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(SETTLE);

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code       <= '0;
      pdet_clr   <= 1'b0;
      settled    <= 1'b0;
      over_range <= 1'b0;
      low_cnt    <= '0;
    end else begin
      pdet_clr <= 1'b0;
      if (start) begin
        code       <= '0;
        settled    <= 1'b0;
        over_range <= 1'b0;
        low_cnt    <= '0;
      end else if (step_tick) begin
        if (sat_q) begin
          pdet_clr <= 1'b1;
          settled  <= 1'b0;
          low_cnt  <= '0;
          if (code == CODE_MAX) over_range <= 1'b1;
          else                  code       <= code + 1'b1;
        end else begin
          if (low_cnt != CNT_TOP) low_cnt <= low_cnt + 1'b1;
          if (low_cnt >= CNT_TOP - 1'b1) settled <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arc_combine.sv
module arc_combine #(
  parameter int CODE_W = 7,
  parameter int FINE_W = 20,
  parameter int OUT_W  = 24,
  parameter int LSB_FF = 100000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     settled,
  input  logic [CODE_W-1:0]        code,
  input  logic                     fine_valid,
  output logic                     fine_ready,
  input  logic signed [FINE_W-1:0] fine_data,
  output logic                     meas_valid,
  input  logic                     meas_ready,
  output logic [OUT_W-1:0]         meas_data
);
  localparam logic [OUT_W-1:0]         LSB_OUT  = OUT_W'(LSB_FF);
  localparam logic signed [FINE_W-1:0] LSB_FINE = FINE_W'(LSB_FF);

  logic [OUT_W-1:0] fine_clamped;
  logic [OUT_W-1:0] coarse;
  logic             take;

  always_comb begin
    if (fine_data[FINE_W-1])     fine_clamped = '0;
    else if (fine_data > LSB_FINE) fine_clamped = LSB_OUT;
    else                         fine_clamped = {{(OUT_W-FINE_W){1'b0}}, fine_data};
  end

  assign coarse     = OUT_W'(code) * LSB_OUT;
  assign fine_ready = settled && !start && (!meas_valid || meas_ready);
  assign take       = fine_valid && fine_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_valid <= 1'b0;
      meas_data  <= '0;
    end else if (start) begin
      meas_valid <= 1'b0;
    end else if (take) begin
      meas_valid <= 1'b1;
      meas_data  <= coarse + fine_clamped;
    end else if (meas_ready) begin
      meas_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/autorange_ctrl.sv
module autorange_ctrl
  import arc_pkg::*;
#(
  parameter int CODE_W = ARC_CODE_W,
  parameter int FINE_W = ARC_FINE_W,
  parameter int OUT_W  = ARC_OUT_W,
  parameter int LSB_FF = ARC_LSB_FF,
  parameter int SETTLE = ARC_SETTLE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     step_tick,
  input  logic                     sat_async,
  output logic                     pdet_clr,
  output logic [CODE_W-1:0]        bank_code,
  output logic                     settled,
  output logic                     over_range,
  input  logic                     fine_valid,
  output logic                     fine_ready,
  input  logic signed [FINE_W-1:0] fine_data,
  output logic                     meas_valid,
  input  logic                     meas_ready,
  output logic [OUT_W-1:0]         meas_data
);
  logic sat_q;

  arc_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sat_async), .q(sat_q)
  );

  arc_stepper #(.CODE_W(CODE_W), .SETTLE(SETTLE)) u_step (
    .clk(clk), .rst_n(rst_n), .start(start), .step_tick(step_tick),
    .sat_q(sat_q), .code(bank_code), .pdet_clr(pdet_clr),
    .settled(settled), .over_range(over_range)
  );

  arc_combine #(.CODE_W(CODE_W), .FINE_W(FINE_W), .OUT_W(OUT_W),
                .LSB_FF(LSB_FF)) u_comb (
    .clk(clk), .rst_n(rst_n), .start(start), .settled(settled),
    .code(bank_code), .fine_valid(fine_valid), .fine_ready(fine_ready),
    .fine_data(fine_data), .meas_valid(meas_valid),
    .meas_ready(meas_ready), .meas_data(meas_data)
  );
endmodule

// File: rtl/autorange_ctrl_chk.sv
module autorange_ctrl_chk #(
  parameter int CODE_W = 7,
  parameter int OUT_W  = 24,
  parameter int LSB_FF = 100000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              step_tick,
  input logic              sat_q,
  input logic [CODE_W-1:0] bank_code,
  input logic              pdet_clr,
  input logic              settled,
  input logic              over_range,
  input logic              fine_ready,
  input logic              meas_valid,
  input logic              meas_ready,
  input logic [OUT_W-1:0]  meas_data
);
  localparam logic [CODE_W-1:0] CMAX = '1;
  localparam longint MAX_OUT = longint'(LSB_FF) * (longint'(CMAX) + 1);

  // R1
  code_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_code != $past(bank_code)) |-> ($past(start) || $past(step_tick && sat_q)));

  // R2
  pdet_after_sat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && sat_q && !start) |=> pdet_clr);

  // R2
  pdet_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdet_clr |=> !pdet_clr);

  // R3
  over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over_range && !start) |=> over_range);

  // R3
  over_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_range |-> (bank_code == CMAX));

  // R4
  settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && sat_q && !start) |=> !settled);

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bank_code == '0 && !settled && !over_range && !meas_valid));

  // R8
  meas_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> (longint'(meas_data) <= MAX_OUT));

  // R9
  meas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !meas_ready && !start) |=> (meas_valid && $stable(meas_data)));

  // R9
  ready_needs_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_ready |-> settled);
endmodule

bind autorange_ctrl autorange_ctrl_chk #(
  .CODE_W(CODE_W), .OUT_W(OUT_W), .LSB_FF(LSB_FF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step_tick(step_tick),
  .sat_q(sat_q), .bank_code(bank_code), .pdet_clr(pdet_clr),
  .settled(settled), .over_range(over_range), .fine_ready(fine_ready),
  .meas_valid(meas_valid), .meas_ready(meas_ready), .meas_data(meas_data)
);

// File: tb/autorange_ctrl_bench.sv
`timescale 1ns/1ps
module autorange_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic step_tick = 1'b0;
  logic sat_async;
  logic pdet_clr;
  logic [6:0] bank_code;
  logic settled;
  logic over_range;
  logic fine_valid = 1'b0;
  logic fine_ready;
  logic signed [19:0] fine_data = '0;
  logic meas_valid;
  logic meas_ready = 1'b0;
  logic [23:0] meas_data;

  int cx = 0;
  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb sat_async = (cx - int'(bank_code) * 100000) >= 100000;

  autorange_ctrl u_autorange_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .step_tick(step_tick),
    .sat_async(sat_async), .pdet_clr(pdet_clr), .bank_code(bank_code),
    .settled(settled), .over_range(over_range), .fine_valid(fine_valid),
    .fine_ready(fine_ready), .fine_data(fine_data), .meas_valid(meas_valid),
    .meas_ready(meas_ready), .meas_data(meas_data)
  );

  localparam int NV = 7;
  localparam int V_CX[NV]   = '{5000000, 0, 99999, 100000, 12750000, 7300000, 20000000};
  localparam int V_FINE[NV] = '{42000, -500, 99999, 0, 50000, 123456, 150000};
  localparam int V_CODE[NV] = '{50, 0, 0, 1, 127, 73, 127};
  localparam int V_OVER[NV] = '{0, 0, 0, 0, 0, 0, 1};
  localparam int V_MEAS[NV] = '{5042000, 0, 99999, 100000, 12750000, 7400000, -1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_once();
    repeat (7) @(negedge clk);
    step_tick = 1'b1;
    @(negedge clk);
    step_tick = 1'b0;
    if (pdet_clr) pulses++;
  endtask

  task automatic restart();
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pulses = 0;
  endtask

  task automatic run_loop();
    for (int t = 0; t < 300; t++) begin
      tick_once();
      if (settled || over_range) break;
    end
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    failures++;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(bank_code == 0 && !pdet_clr && !settled && !over_range && !fine_ready && !meas_valid,
        "R10 reset", int'(bank_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cx = V_CX[i];
      restart();
      run_loop();
      // R6 settle code
      chk(int'(bank_code) == V_CODE[i], "R6 code", int'(bank_code), V_CODE[i]);
      chk(int'(over_range) == V_OVER[i], "R3 over", int'(over_range), V_OVER[i]);
      if (V_OVER[i] == 0) begin
        // R2 one pulse per advance
        chk(pulses == V_CODE[i], "R2 pulses", pulses, V_CODE[i]);
        fine_data = 20'(V_FINE[i]);
        fine_valid = 1'b1;
        for (int w = 0; w < 20; w++) begin
          if (fine_ready) break;
          @(negedge clk);
        end
        @(negedge clk);
        fine_valid = 1'b0;
        // R7 R8 combined result
        chk(meas_valid && int'(meas_data) == V_MEAS[i], "R8 meas", int'(meas_data), V_MEAS[i]);
        repeat (3) @(negedge clk);
        // R9 held under back-pressure
        chk(meas_valid && int'(meas_data) == V_MEAS[i], "R9 hold", int'(meas_data), V_MEAS[i]);
        meas_ready = 1'b1;
        @(negedge clk);
        meas_ready = 1'b0;
        chk(!meas_valid, "R9 drain", int'(meas_valid), 0);
      end else begin
        // R9 no fine accept while unsettled
        chk(!fine_ready, "R9 ready", int'(fine_ready), 0);
      end
    end

    // R3 over-range sticky after flag falls, code held
    cx = 0;
    repeat (4) tick_once();
    chk(over_range && bank_code == 127, "R3 sticky", int'(bank_code), 127);
    restart();
    // R5 start clears
    chk(!over_range && bank_code == 0 && !settled, "R5 clear", int'(bank_code), 0);

    // R4 settle timing with a 250 pF sensor
    cx = 250000;
    restart();
    tick_once();
    tick_once();
    chk(bank_code == 2 && !settled, "R4 advanced", int'(bank_code), 2);
    tick_once();
    chk(!settled, "R4 first low tick", int'(settled), 0);
    tick_once();
    chk(settled && !pdet_clr, "R4 second low tick", int'(settled), 1);

    // R1 flag high without ticks leaves code alone
    cx = 9000000;
    repeat (60) @(negedge clk);
    chk(bank_code == 2, "R1 no tick", int'(bank_code), 2);
    tick_once();
    chk(bank_code == 3 && pdet_clr, "R1 tick steps", int'(bank_code), 3);
    repeat (3) @(negedge clk);
    chk(!pdet_clr, "R2 pulse width", int'(pdet_clr), 0);

    // R5 start wins over a tick in the same cycle
    repeat (7) @(negedge clk);
    start = 1'b1;
    step_tick = 1'b1;
    @(negedge clk);
    start = 1'b0;
    step_tick = 1'b0;
    chk(bank_code == 0 && !pdet_clr, "R5 start priority", int'(bank_code), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule